// File: doc/BRIEF.md
# Streaming 2D Convolution Engine with Partial-Sum Input

This block applies a K×K filter to an image that arrives one pixel per transfer in raster order. Each result is the dot product of the filter with a K×K window of the image, added to a value taken from a second stream, the partial-sum plane. Several input maps can therefore be folded into one output map by feeding the result plane of one pass back in as the partial-sum plane of the next.

Pixels and weights are signed Q8.8 words of 16 bits. Products and sums are kept at 32 bits, so the partial-sum and result streams are Q16.16. The image width is set at run time. Earlier rows are held in K-1 line buffers. The filter has two banks. A new filter is written into the shadow bank while the active bank keeps serving the current image. The shadow bank becomes active only when the first pixel of the next image is consumed. The pixel, partial-sum and result streams each pass through a small FIFO. When data is missing or the result FIFO is full, the engine waits and loses nothing.

Top module: `conv2d_stream`

## Requirements
- R1: For a window whose top-left pixel sits at row i, column j, the result equals p + Σ x(i+m, j+n)·w(m,n) over m,n in 0..K-1, wrapped to 32 bits. Here p is the next partial-sum word, and the products are signed 16×16 multiplications taken at 32 bits.
- R2: Results are produced only for complete windows, in raster order of their top-left corner. An H×W image gives exactly (H-K+1)·(W-K+1) results, and none after that.
- R3: The row length comes from `cfg_width` and may change between images. With a width equal to K, each row from K-1 onward gives exactly one result.
- R4: With all streams continuously available, the results of one output row leave on consecutive clock cycles, one per cycle.
- R5: Gaps in the pixel or partial-sum streams stall the engine. No data is lost or duplicated.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R7: One partial-sum word is consumed for each result and for nothing else, so the partial-sum plane stays aligned with the windows.
- R8: Weights are written in raster order, word m·K+n to w(m,n). Once K·K words are held in the shadow bank, `wt_ready` is low until the bank is made active.
- R9: A loaded shadow bank becomes active only when a pixel marked with `pix_sof` (the first pixel of an image) is consumed. An image in progress keeps its filter even if a new one finishes loading during it.
- R10: If no new filter has been loaded, the next image uses the filter that is already active.
- R11: After reset `out_valid` is low, all input ready signals are high, and the active filter is all zeros, so every result equals its partial-sum word.
- R12: Full-scale negative and positive operands give the exact two's-complement 32-bit result, including wraparound of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | $clog2(MAX_WIDTH+1) | Image row length in pixels, K..MAX_WIDTH |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Pixel FIFO can accept |
| pix_sof | input | 1 | Marks the first pixel of an image |
| pix_data | input | 16 | Signed Q8.8 pixel |
| acc_valid | input | 1 | Partial-sum word offered |
| acc_ready | output | 1 | Partial-sum FIFO can accept |
| acc_data | input | 32 | Signed Q16.16 partial sum |
| wt_valid | input | 1 | Weight word offered |
| wt_ready | output | 1 | Shadow bank can accept a weight |
| wt_data | input | 16 | Signed Q8.8 weight |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 32 | Signed Q16.16 result |

## Verification
The hardest case to reach is a filter that finishes loading while an image is still streaming. The bank swap must then wait for the next start marker and must not happen mid-image. The bench starts the weight stream a few cycles after an image's first pixel, in parallel with the pixel and partial-sum streams. It uses a different, asymmetric filter for each pass, so a swap taken too early, too late, or with weights in the wrong order changes the result values. Stalls are produced by gaps in the input streams together with a periodic low on `out_ready`. Each held result is compared on the next cycle.

// File: rtl/conv_pkg.sv
package conv_pkg;
   localparam int unsigned PIX_W = 16;
   localparam int unsigned SUM_W = 32;

   typedef logic signed [PIX_W-1:0] pix_t;
   typedef logic signed [SUM_W-1:0] sum_t;

   function automatic sum_t widen_mul(input pix_t a, input pix_t b);
      return sum_t'(a) * sum_t'(b);
   endfunction
endpackage

// File: rtl/conv_fifo.sv
module conv_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("conv_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign dout  = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp[AW-1:0]] <= din;
   end

   assert_fifo_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_fifo_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/conv_window.sv
module conv_window #(
   parameter int KSZ       = 3,
   parameter int MAX_WIDTH = 64,
   parameter int IDX_W     = $clog2(MAX_WIDTH)
) (
   input  logic                               clk,
   input  logic                               shift_en,
   input  logic [IDX_W-1:0]                   col_idx,
   input  conv_pkg::pix_t                     pix_in,
   output conv_pkg::pix_t [KSZ-1:0][KSZ-1:0]  win_o
);
   import conv_pkg::*;

   pix_t lb [KSZ-1][MAX_WIDTH];
   pix_t col_v [KSZ];
   pix_t win_q [KSZ][KSZ];

   // column entering the window: oldest row at index 0, new pixel at KSZ-1
   always_comb begin
      col_v[KSZ-1] = pix_in;
      for (int m = 0; m < KSZ-1; m++) col_v[m] = lb[KSZ-2-m][col_idx];
   end

   always_comb begin
      for (int m = 0; m < KSZ; m++) begin
         for (int n = 0; n < KSZ-1; n++) win_o[m][n] = win_q[m][n+1];
         win_o[m][KSZ-1] = col_v[m];
      end
   end

   always_ff @(posedge clk) begin
      if (shift_en) begin
         for (int m = 0; m < KSZ; m++)
            for (int n = 0; n < KSZ; n++) win_q[m][n] <= win_o[m][n];
      end
   end

   for (genvar k = 0; k < KSZ-1; k++) begin : g_line
      if (k == 0) begin : g_first
         always_ff @(posedge clk) if (shift_en) lb[0][col_idx] <= pix_in;
      end else begin : g_chain
         always_ff @(posedge clk) if (shift_en) lb[k][col_idx] <= lb[k-1][col_idx];
      end
   end
endmodule

// File: rtl/conv_kbank.sv
module conv_kbank #(
   parameter int KSZ = 3,
   parameter int KK  = KSZ * KSZ
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wt_valid,
   input  conv_pkg::pix_t              wt_data,
   output logic                        wt_ready,
   input  logic                        swap_req,
   output conv_pkg::pix_t [KK-1:0]     wts_o
);
   import conv_pkg::*;
   localparam int CW = $clog2(KK + 1);

   pix_t [KK-1:0] shadow_q, active_q;
   logic [CW-1:0] fill_q;
   logic          loaded, do_swap, do_load;

   assign loaded   = (fill_q == CW'(KK));
   assign wt_ready = !loaded;
   assign do_swap  = swap_req && loaded;
   assign do_load  = wt_valid && wt_ready;
   assign wts_o    = active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q   <= '0;
         shadow_q <= '0;
         active_q <= '0;
      end else if (do_swap) begin
         active_q <= shadow_q;
         fill_q   <= '0;
      end else if (do_load) begin
         shadow_q[fill_q] <= wt_data;
         fill_q           <= fill_q + 1'b1;
      end
   end

   assert_active_only_on_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !do_swap |=> $stable(active_q));
   assert_load_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      do_load |-> (fill_q < CW'(KK)));
endmodule

// File: rtl/conv_mac.sv
module conv_mac #(
   parameter int KSZ = 3,
   parameter int KK  = KSZ * KSZ
) (
   input  conv_pkg::pix_t [KSZ-1:0][KSZ-1:0] win_i,
   input  conv_pkg::pix_t [KK-1:0]           wts_i,
   input  conv_pkg::sum_t                    psum_i,
   output conv_pkg::sum_t                    sum_o
);
   import conv_pkg::*;

   sum_t prod [KK];

   for (genvar m = 0; m < KSZ; m++) begin : g_row
      for (genvar n = 0; n < KSZ; n++) begin : g_col
         assign prod[m*KSZ+n] = widen_mul(win_i[m][n], wts_i[m*KSZ+n]);
      end
   end

   always_comb begin
      sum_o = psum_i;
      for (int i = 0; i < KK; i++) sum_o = sum_o + prod[i];
   end
endmodule

// File: rtl/conv2d_stream.sv
module conv2d_stream #(
   parameter int KSZ        = 3,
   parameter int MAX_WIDTH  = 64,
   parameter int FIFO_DEPTH = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [$clog2(MAX_WIDTH+1)-1:0] cfg_width,
   input  logic                           pix_valid,
   output logic                           pix_ready,
   input  logic                           pix_sof,
   input  logic [15:0]                    pix_data,
   input  logic                           acc_valid,
   output logic                           acc_ready,
   input  logic [31:0]                    acc_data,
   input  logic                           wt_valid,
   output logic                           wt_ready,
   input  logic [15:0]                    wt_data,
   output logic                           out_valid,
   input  logic                           out_ready,
   output logic [31:0]                    out_data
);
   import conv_pkg::*;

   localparam int KK    = KSZ * KSZ;
   localparam int WID_W = $clog2(MAX_WIDTH + 1);
   localparam int IDX_W = $clog2(MAX_WIDTH);
   localparam int RW    = $clog2(KSZ);

   if (KSZ < 2) begin : g_bad_k
      $error("conv2d_stream: KSZ must be at least 2");
   end
   if (MAX_WIDTH < KSZ) begin : g_bad_w
      $error("conv2d_stream: MAX_WIDTH must be at least KSZ");
   end
   if (PIX_W != 16 || SUM_W != 32) begin : g_bad_fmt
      $error("conv2d_stream: port widths assume 16-bit pixels and 32-bit sums");
   end

   // input and output queues
   logic             pf_full, pf_empty, pf_pop;
   logic [PIX_W:0]   pf_dout;
   logic             af_full, af_empty, af_pop;
   logic [SUM_W-1:0] af_dout;
   logic             of_full, of_empty, of_push;
   sum_t             mac_sum;

   conv_fifo #(.W(PIX_W+1), .DEPTH(FIFO_DEPTH)) pix_q_i (
      .clk(clk), .rst_n(rst_n),
      .push(pix_valid && !pf_full), .din({pix_sof, pix_data}), .full(pf_full),
      .pop(pf_pop), .dout(pf_dout), .empty(pf_empty));

   conv_fifo #(.W(SUM_W), .DEPTH(FIFO_DEPTH)) psum_q_i (
      .clk(clk), .rst_n(rst_n),
      .push(acc_valid && !af_full), .din(acc_data), .full(af_full),
      .pop(af_pop), .dout(af_dout), .empty(af_empty));

   conv_fifo #(.W(SUM_W), .DEPTH(FIFO_DEPTH)) res_q_i (
      .clk(clk), .rst_n(rst_n),
      .push(of_push), .din(mac_sum), .full(of_full),
      .pop(out_ready && !of_empty), .dout(out_data), .empty(of_empty));

   assign pix_ready = !pf_full;
   assign acc_ready = !af_full;
   assign out_valid = !of_empty;

   // position tracking
   logic             head_sof, emit, fire, wrap;
   pix_t             head_pix;
   logic [IDX_W-1:0] col_q, col_pos, col_nxt;
   logic [RW-1:0]    row_q, row_pos;
   logic [WID_W-1:0] col_plus;

   assign head_sof = pf_dout[PIX_W];
   assign head_pix = pf_dout[PIX_W-1:0];
   assign col_pos  = head_sof ? '0 : col_q;
   assign row_pos  = head_sof ? '0 : row_q;
   assign emit     = (row_pos == RW'(KSZ-1)) && (col_pos >= IDX_W'(KSZ-1));
   assign fire     = !pf_empty && (!emit || (!af_empty && !of_full));
   assign pf_pop   = fire;
   assign af_pop   = fire && emit;
   assign of_push  = fire && emit;
   assign col_plus = WID_W'(col_pos) + WID_W'(1);
   assign wrap     = (col_plus >= cfg_width);
   assign col_nxt  = wrap ? '0 : col_plus[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (fire) begin
         col_q <= col_nxt;
         row_q <= (wrap && row_pos != RW'(KSZ-1)) ? row_pos + 1'b1 : row_pos;
      end
   end

   // datapath
   pix_t [KSZ-1:0][KSZ-1:0] win;
   pix_t [KK-1:0]           wts;

   conv_window #(.KSZ(KSZ), .MAX_WIDTH(MAX_WIDTH), .IDX_W(IDX_W)) win_i (
      .clk(clk), .shift_en(fire), .col_idx(col_pos), .pix_in(head_pix), .win_o(win));

   conv_kbank #(.KSZ(KSZ), .KK(KK)) bank_i (
      .clk(clk), .rst_n(rst_n), .wt_valid(wt_valid), .wt_data(wt_data),
      .wt_ready(wt_ready), .swap_req(fire && head_sof), .wts_o(wts));

   conv_mac #(.KSZ(KSZ), .KK(KK)) mac_i (
      .win_i(win), .wts_i(wts), .psum_i(af_dout), .sum_o(mac_sum));

   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/conv2d_stream_tb_top.sv
module conv2d_stream_tb_top;
   localparam int K = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  cfg_width;
   logic        pix_valid, pix_ready, pix_sof;
   logic [15:0] pix_data;
   logic        acc_valid, acc_ready;
   logic [31:0] acc_data;
   logic        wt_valid, wt_ready;
   logic [15:0] wt_data;
   logic        out_valid, out_ready;
   logic [31:0] out_data;

   conv2d_stream dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_sof(pix_sof), .pix_data(pix_data),
      .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_data(acc_data),
      .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_data(wt_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   always @(posedge clk) cyc++;

   int img [16][16];
   int psum [256];
   int want [256];
   int got [256];
   int stamp [256];
   int n_got;

   task automatic check(input bit ok, input string tag, input int act, input int exv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exv);
      end
   endtask

   task automatic load_kernel(input int kk[9]);
      for (int i = 0; i < K*K; i++) begin
         wt_valid = 1'b1;
         wt_data  = 16'(kk[i]);
         while (!wt_ready) @(negedge clk);
         @(negedge clk);
      end
      wt_valid = 1'b0;
   endtask

   task automatic run_image(input int h, input int w, input int seed, input bit stall,
                            input int kk[9], input bit preload, input int nk[9],
                            input string tag, input bit chk_rate);
      int n_out;
      n_out = (h-K+1) * (w-K+1);
      for (int r = 0; r < h; r++)
         for (int c = 0; c < w; c++)
            img[r][c] = stall ? ((r*7919 + c*104729 + seed*31) % 60001) - 30000
                              : ((r*13 + c*7 + seed) % 41) - 20;
      for (int i = 0; i < n_out; i++) psum[i] = i*12345 + seed*777 - 50000;
      for (int i = 0; i <= h-K; i++)
         for (int j = 0; j <= w-K; j++) begin
            int s;
            s = psum[i*(w-K+1)+j];
            for (int m = 0; m < K; m++)
               for (int n = 0; n < K; n++) s += img[i+m][j+n] * kk[m*K+n];
            want[i*(w-K+1)+j] = s;
         end
      cfg_width = 7'(w);
      n_got = 0;
      fork
         begin
            for (int i = 0; i < h*w; i++) begin
               if (stall && (i % 3 == 2)) begin pix_valid = 1'b0; @(negedge clk); end
               pix_valid = 1'b1;
               pix_data  = 16'(img[i / w][i % w]);
               pix_sof   = (i == 0);
               while (!pix_ready) @(negedge clk);
               @(negedge clk);
            end
            pix_valid = 1'b0;
            pix_sof   = 1'b0;
         end
         begin
            for (int i = 0; i < n_out; i++) begin
               if (stall && (i % 4 == 1)) begin acc_valid = 1'b0; repeat (2) @(negedge clk); end
               acc_valid = 1'b1;
               acc_data  = 32'(psum[i]);
               while (!acc_ready) @(negedge clk);
               @(negedge clk);
            end
            acc_valid = 1'b0;
         end
         begin
            if (preload) begin
               repeat (5) @(negedge clk);
               load_kernel(nk);
            end
         end
         begin
            while (n_got < n_out) begin
               bit held;
               logic [31:0] held_d;
               held = 1'b0;
               held_d = '0;
               out_ready = stall ? ((cyc % 5) < 2) : 1'b1;
               if (out_valid && out_ready) begin
                  got[n_got] = out_data;
                  stamp[n_got] = cyc;
                  n_got++;
               end else if (out_valid) begin
                  held = 1'b1;
                  held_d = out_data;
               end
               @(negedge clk);
               if (held) check(out_valid && out_data == held_d, "R6 held result",
                               int'(out_data), int'(held_d));
            end
            out_ready = 1'b0;
         end
      join
      for (int i = 0; i < n_out; i++)
         check(got[i] == want[i], tag, got[i], want[i]);
      if (chk_rate) begin
         for (int i = 0; i + 1 < n_out; i++)
            if ((i + 1) % (w-K+1) != 0)
               check(stamp[i+1] - stamp[i] == 1, "R4 one result per cycle",
                     stamp[i+1] - stamp[i], 1);
      end
      out_ready = 1'b1;
      repeat (12) @(negedge clk);
      check(!out_valid, "R2 no extra result", int'(out_valid), 0);
      out_ready = 1'b0;
   endtask

   int kz [9] = '{default: 0};
   int ka [9] = '{1, 2, 3, -4, 5, -6, 7, 8, -9};
   int kb [9] = '{30000, -29000, 123, -32768, 32767, -1, 17000, -250, 9999};
   int kc [9] = '{-3, 0, 11, 6, -2, 1, 4, -7, 5};
   int kd [9] = '{9, -8, 7, -6, 5, -4, 3, -2, 1};

   task automatic t_reset();
      check(!out_valid, "R11 out_valid after reset", int'(out_valid), 0);
      check(pix_ready, "R11 pix_ready after reset", int'(pix_ready), 1);
      check(acc_ready, "R11 acc_ready after reset", int'(acc_ready), 1);
      check(wt_ready, "R11 wt_ready after reset", int'(wt_ready), 1);
   endtask

   task automatic t_zero_kernel();
      run_image(4, 4, 1, 1'b0, kz, 1'b0, kz, "R11 zero filter passes partial sum", 1'b0);
   endtask

   task automatic t_basic();
      load_kernel(ka);
      run_image(5, 6, 2, 1'b0, ka, 1'b0, kz, "R1 R2 R7 result value", 1'b1);
   endtask

   task automatic t_stall();
      load_kernel(kb);
      run_image(4, 7, 3, 1'b1, kb, 1'b0, kz, "R5 R12 stalled full-scale result", 1'b0);
   endtask

   task automatic t_preload();
      load_kernel(kc);
      check(!wt_ready, "R8 wt_ready low with full shadow bank", int'(wt_ready), 0);
      run_image(5, 6, 4, 1'b0, kc, 1'b1, kd, "R9 filter kept during image", 1'b0);
      run_image(4, 5, 5, 1'b1, kd, 1'b0, kz, "R9 preloaded filter used next image", 1'b0);
   endtask

   task automatic t_reuse_narrow();
      run_image(5, 3, 6, 1'b0, kd, 1'b0, kz, "R10 R3 reused filter at width K", 1'b0);
   endtask

   initial begin
      rst_n = 1'b0;
      cfg_width = 7'd8;
      pix_valid = 1'b0; pix_sof = 1'b0; pix_data = '0;
      acc_valid = 1'b0; acc_data = '0;
      wt_valid = 1'b0; wt_data = '0;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_kernel();
      t_basic();
      t_stall();
      t_preload();
      t_reuse_narrow();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", n_got, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule